// File: doc/BRIEF.md
# Sticky Error Status Capture Register

This block collects error reports from a memory or bus error path into one 64-bit status word and one fault address register. Each error event arrives as a single-cycle pulse with a class index, a fault address, a 9-bit data syndrome and a 4-bit tag syndrome. The event sets a sticky status bit for its class and, for uncorrectable and software-correctable classes, raises a multiple-error flag if that bit was already set. Each event also records the current privilege level.

The fault address and the two syndrome fields are shared by all classes. Each of these fields locks onto the highest-ranked event that it has taken. A later event replaces it only if that event has a strictly higher rank. The field unlocks when software clears the status bit of the event it holds, even if lower-ranked bits are still set. After an unlock the field keeps its value until the next capture. Within one 64-byte transfer, only the first reported error is logged. The event input has no back-pressure: the block accepts an event in every cycle in which `evt_valid` is high, so there is no ready signal. Software writes to the status word with write-one-to-clear semantics, and reading the word has no side effects.

Top module: `err_status_capture`

## Requirements
- R1: After reset, `status_rdata`, `addr_rdata` and `irq` are all zero.
- R2: A logged event of class k (0..18) sets status bit 33+k one cycle later. The bit stays set, and reading never clears it, until software clears it.
- R3: When `wr_en` is high, each 1 in `wr_data` bits 53:33 clears the matching status bit, and each 0 leaves that bit unchanged. Bits 19:16 (tag syndrome), bits 8:0 (data syndrome) and all other bits ignore writes.
- R4: Bit 53 is set when an uncorrectable or software-correctable event arrives while its own status bit is already set. A repeat of a hardware-corrected class does not set it. With the default masks, class 0 is hardware-corrected, classes 1 and 2 are uncorrectable, and class 9 is software-correctable.
- R5: An event with `evt_same_txn` high that follows an earlier logged event is ignored. It changes no status bit, does not set bit 53, and captures nothing.
- R6: Bit 52 takes the value of `priv_in` on every logged event.
- R7: The address register captures a logged event when it is unlocked, or when the event's rank is strictly higher than the held rank. The ranks are: uncorrectable above software-correctable above hardware-corrected. An event of equal or lower rank does not overwrite the held value.
- R8: A locked field unlocks when software clears the status bit of the class it holds, whatever other bits remain set. The field keeps its value until the next capture.
- R9: The data syndrome (bits 8:0) captures only classes in the data mask, which by default are classes 0-9, 12 and 13. The tag syndrome (bits 19:16) captures only classes 14 and 15. Both follow the rules of R7 and R8.
- R10: If an event and a software clear of the same bit happen in the same cycle, the bit stays set, and every participating field that held that class captures the new event.
- R11: `irq` is high exactly when `irq_en` is high and at least one of bits 51:33 is set.
- R12: An event with a class index of 19 or above has no effect on the status word or the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event pulse; accepted every cycle |
| evt_class | input | 5 | Error class index |
| evt_same_txn | input | 1 | Event belongs to the same 64-byte transfer as the previous one |
| evt_addr | input | ADDR_W | Fault address of the event |
| evt_dsyn | input | 9 | Data ECC syndrome of the event |
| evt_tsyn | input | 4 | Tag ECC syndrome of the event |
| priv_in | input | 1 | Current privilege level |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 64 | Write-one-to-clear data |
| irq_en | input | 1 | Global interrupt enable |
| status_rdata | output | 64 | Status word read value |
| addr_rdata | output | ADDR_W | Fault address read value |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: a 48-bit address, the default class masks, a single software-correctable class, and the tag syndrome restricted to two classes. With this set-up, all three ranks can be reached, and some classes take part in the address capture but not in a syndrome capture. This exposes the case where one field relocks while another stays locked. The directed scenarios cover overwrites by strictly higher ranks, refused overwrites by equal ranks, unlocking by clearing a non-held bit versus the held bit, and a set and clear in the same cycle. A random phase mixes out-of-range classes, same-transfer events and writes with arbitrary data, and checks the results against a behavioural model.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int NCLS     = 19;
  localparam int STK_LO   = 33;
  localparam int STK_HI   = STK_LO + NCLS - 1;
  localparam int PRIV_BIT = 52;
  localparam int ME_BIT   = 53;
  localparam int DSYN_W   = 9;
  localparam int TSYN_W   = 4;
  localparam int TSYN_LO  = 16;
  localparam int CLS_W    = 5;

  typedef enum logic [1:0] {
    RANK_HW  = 2'd0,
    RANK_SW  = 2'd1,
    RANK_UNC = 2'd2
  } rank_e;
endpackage

// File: rtl/esc_status.sv
module esc_status
  import esr_pkg::*;
#(
  parameter logic [NCLS-1:0] UNC_MASK = 19'h75D56,
  parameter logic [NCLS-1:0] SWC_MASK = 19'h00200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [CLS_W-1:0] evt_class,
  input  logic             evt_same_txn,
  input  logic             priv_in,
  input  logic [NCLS-1:0]  clr_vec,
  input  logic             clr_me,
  input  logic             clr_priv,
  output logic [NCLS-1:0]  set_vec,
  output rank_e            log_rank,
  output logic [NCLS-1:0]  sticky_q,
  output logic             me_q,
  output logic             priv_q
);
  logic cls_ok;
  logic logged;
  logic txn_open_q;
  logic is_unc;
  logic is_swc;
  logic repeat_hit;

  assign cls_ok = evt_class < CLS_W'(NCLS);
  assign logged = evt_valid && cls_ok && !(evt_same_txn && txn_open_q);

  for (genvar g = 0; g < NCLS; g++) begin : g_dec
    assign set_vec[g] = logged && (evt_class == CLS_W'(g));
  end

  assign is_unc   = |(set_vec & UNC_MASK);
  assign is_swc   = |(set_vec & SWC_MASK);
  assign log_rank = is_unc ? RANK_UNC : (is_swc ? RANK_SW : RANK_HW);

  // Repeat of a class whose bit is already set; hardware-corrected excluded.
  assign repeat_hit = (is_unc || is_swc) && |(set_vec & sticky_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q   <= '0;
      me_q       <= 1'b0;
      priv_q     <= 1'b0;
      txn_open_q <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~clr_vec) | set_vec;
      if (repeat_hit)    me_q <= 1'b1;
      else if (clr_me)   me_q <= 1'b0;
      if (logged)        priv_q <= priv_in;
      else if (clr_priv) priv_q <= 1'b0;
      if (logged)        txn_open_q <= 1'b1;
    end
  end

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  p_me_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(me_q) |-> $past(evt_valid));

  p_drop_same_txn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_same_txn && txn_open_q) |-> (set_vec == '0));
endmodule

// File: rtl/esc_capture.sv
module esc_capture
  import esr_pkg::*;
#(
  parameter int              W         = 8,
  parameter logic [NCLS-1:0] PART_MASK = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] set_vec,
  input  rank_e           log_rank,
  input  logic [W-1:0]    log_val,
  input  logic [NCLS-1:0] clr_vec,
  output logic [W-1:0]    val_q
);
  logic            locked_q;
  logic [NCLS-1:0] held_q;
  rank_e           rank_q;
  logic            part;
  logic            unlock_now;
  logic            still_locked;
  logic            take;

  assign part         = |(set_vec & PART_MASK);
  assign unlock_now   = locked_q && |(held_q & clr_vec);
  assign still_locked = locked_q && !unlock_now;
  assign take         = part && (!still_locked || (log_rank > rank_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      held_q   <= '0;
      rank_q   <= RANK_HW;
      val_q    <= '0;
    end else if (take) begin
      locked_q <= 1'b1;
      held_q   <= set_vec;
      rank_q   <= log_rank;
      val_q    <= log_val;
    end else if (unlock_now) begin
      locked_q <= 1'b0;
    end
  end

  p_take_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> locked_q);

  p_no_demote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (still_locked && part && !(log_rank > rank_q)) |=> $stable(val_q));

  p_value_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !part |=> $stable(val_q));
endmodule

// File: rtl/err_status_capture.sv
module err_status_capture
  import esr_pkg::*;
#(
  parameter int              ADDR_W    = 48,
  parameter logic [NCLS-1:0] UNC_MASK  = 19'h75D56,
  parameter logic [NCLS-1:0] SWC_MASK  = 19'h00200,
  parameter logic [NCLS-1:0] ADDR_MASK = 19'h7FFFF,
  parameter logic [NCLS-1:0] DSYN_MASK = 19'h033FF,
  parameter logic [NCLS-1:0] TSYN_MASK = 19'h0C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CLS_W-1:0]  evt_class,
  input  logic              evt_same_txn,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DSYN_W-1:0] evt_dsyn,
  input  logic [TSYN_W-1:0] evt_tsyn,
  input  logic              priv_in,
  input  logic              wr_en,
  input  logic [63:0]       wr_data,
  input  logic              irq_en,
  output logic [63:0]       status_rdata,
  output logic [ADDR_W-1:0] addr_rdata,
  output logic              irq
);
  logic [NCLS-1:0]   clr_vec;
  logic [NCLS-1:0]   set_vec;
  logic [NCLS-1:0]   sticky_q;
  rank_e             log_rank;
  logic              me_q;
  logic              priv_q;
  logic [DSYN_W-1:0] dsyn_q;
  logic [TSYN_W-1:0] tsyn_q;
  logic              wr_unused;

  assign clr_vec   = wr_en ? wr_data[STK_HI:STK_LO] : '0;
  assign wr_unused = ^{wr_data[63:ME_BIT+1], wr_data[STK_LO-1:0]};

  esc_status #(.UNC_MASK(UNC_MASK), .SWC_MASK(SWC_MASK)) u_status (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_class(evt_class), .evt_same_txn(evt_same_txn),
    .priv_in(priv_in), .clr_vec(clr_vec),
    .clr_me(wr_en && wr_data[ME_BIT]), .clr_priv(wr_en && wr_data[PRIV_BIT]),
    .set_vec(set_vec), .log_rank(log_rank), .sticky_q(sticky_q),
    .me_q(me_q), .priv_q(priv_q)
  );

  esc_capture #(.W(ADDR_W), .PART_MASK(ADDR_MASK)) u_cap_addr (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .log_rank(log_rank),
    .log_val(evt_addr), .clr_vec(clr_vec), .val_q(addr_rdata)
  );

  esc_capture #(.W(DSYN_W), .PART_MASK(DSYN_MASK)) u_cap_dsyn (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .log_rank(log_rank),
    .log_val(evt_dsyn), .clr_vec(clr_vec), .val_q(dsyn_q)
  );

  esc_capture #(.W(TSYN_W), .PART_MASK(TSYN_MASK)) u_cap_tsyn (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .log_rank(log_rank),
    .log_val(evt_tsyn), .clr_vec(clr_vec), .val_q(tsyn_q)
  );

  always_comb begin
    status_rdata                           = '0;
    status_rdata[DSYN_W-1:0]               = dsyn_q;
    status_rdata[TSYN_LO+TSYN_W-1:TSYN_LO] = tsyn_q;
    status_rdata[STK_HI:STK_LO]            = sticky_q;
    status_rdata[PRIV_BIT]                 = priv_q;
    status_rdata[ME_BIT]                   = me_q;
  end

  assign irq = irq_en && (sticky_q != '0);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (status_rdata[STK_HI:STK_LO] != '0)));

  p_bad_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_class >= CLS_W'(NCLS)) && !wr_en)
      |=> ($stable(status_rdata) && $stable(addr_rdata)));
endmodule

// File: tb/err_status_capture_tb.sv
module err_status_capture_tb;
  localparam int ADDR_W = 48;
  localparam logic [18:0] B_UNC = 19'h75D56;
  localparam logic [18:0] B_SWC = 19'h00200;
  localparam logic [18:0] B_AD  = 19'h7FFFF;
  localparam logic [18:0] B_DS  = 19'h033FF;
  localparam logic [18:0] B_TS  = 19'h0C000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [4:0] evt_class = '0;
  logic evt_same_txn = 1'b0;
  logic [ADDR_W-1:0] evt_addr = '0;
  logic [8:0] evt_dsyn = '0;
  logic [3:0] evt_tsyn = '0;
  logic priv_in = 1'b0;
  logic wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic irq_en = 1'b0;
  logic [63:0] status_rdata;
  logic [ADDR_W-1:0] addr_rdata;
  logic irq;

  always #4 clk = ~clk;

  err_status_capture u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_class(evt_class),
    .evt_same_txn(evt_same_txn), .evt_addr(evt_addr), .evt_dsyn(evt_dsyn),
    .evt_tsyn(evt_tsyn), .priv_in(priv_in), .wr_en(wr_en), .wr_data(wr_data),
    .irq_en(irq_en), .status_rdata(status_rdata), .addr_rdata(addr_rdata), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  // Behavioural reference model
  bit m_stk[19];
  bit m_me = 0, m_priv = 0, m_open = 0;
  bit m_lk[3];
  int m_held[3];
  int m_rk[3];
  logic [63:0] m_val[3];

  function automatic int rank_of(int c);
    if (B_UNC[c]) return 2;
    if (B_SWC[c]) return 1;
    return 0;
  endfunction

  function automatic bit in_cap(int k, int c);
    case (k)
      0: return B_AD[c];
      1: return B_DS[c];
      default: return B_TS[c];
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 19; i++) m_stk[i] = 0;
    for (int k = 0; k < 3; k++) begin
      m_lk[k] = 0; m_held[k] = 0; m_rk[k] = 0; m_val[k] = '0;
    end
    m_me = 0; m_priv = 0; m_open = 0;
  endtask

  task automatic model_step();
    bit logged;
    int c;
    int rk;
    bit unl;
    bit still;
    c = int'(evt_class);
    logged = evt_valid && (c < 19) && !(evt_same_txn && m_open);
    rk = logged ? rank_of(c) : 0;
    if (logged && rk > 0 && m_stk[c]) m_me = 1;
    else if (wr_en && wr_data[53]) m_me = 0;
    if (logged) m_priv = priv_in;
    else if (wr_en && wr_data[52]) m_priv = 0;
    for (int k = 0; k < 3; k++) begin
      unl = m_lk[k] && wr_en && wr_data[33 + m_held[k]];
      still = m_lk[k] && !unl;
      if (logged && in_cap(k, c) && (!still || rk > m_rk[k])) begin
        m_lk[k] = 1; m_held[k] = c; m_rk[k] = rk;
        m_val[k] = (k == 0) ? 64'(evt_addr) : (k == 1) ? 64'(evt_dsyn) : 64'(evt_tsyn);
      end else if (unl) begin
        m_lk[k] = 0;
      end
    end
    for (int i = 0; i < 19; i++) if (wr_en && wr_data[33 + i]) m_stk[i] = 0;
    if (logged) begin
      m_stk[c] = 1;
      m_open = 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  function automatic logic [63:0] exp_status();
    logic [63:0] s;
    s = '0;
    s[8:0] = m_val[1][8:0];
    s[19:16] = m_val[2][3:0];
    for (int i = 0; i < 19; i++) s[33 + i] = m_stk[i];
    s[52] = m_priv;
    s[53] = m_me;
    return s;
  endfunction

  function automatic bit exp_irq();
    bit any;
    any = 0;
    for (int i = 0; i < 19; i++) any |= m_stk[i];
    return irq_en && any;
  endfunction

  task automatic compare();
    checks++;
    if (status_rdata !== exp_status()) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", cur_req, status_rdata, exp_status());
    end
    checks++;
    if (addr_rdata !== m_val[0][ADDR_W-1:0]) begin
      errors++;
      $display("FAIL %s addr actual=%h expected=%h", cur_req, addr_rdata, m_val[0][ADDR_W-1:0]);
    end
    checks++;
    if (irq !== exp_irq()) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", cur_req, irq, exp_irq());
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    evt_valid = 0; evt_same_txn = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic send(input int cls, input logic [ADDR_W-1:0] a, input logic [8:0] ds,
                      input logic [3:0] ts, input bit same, input bit pv);
    evt_valid = 1; evt_class = 5'(cls); evt_addr = a; evt_dsyn = ds;
    evt_tsyn = ts; evt_same_txn = same; priv_in = pv;
    step();
    idle_inputs();
  endtask

  task automatic wr(input logic [63:0] d);
    wr_en = 1; wr_data = d;
    step();
    idle_inputs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic logic [63:0] bitmask(input int cls);
    return 64'd1 << (33 + cls);
  endfunction

  initial begin
    // R1: reset state
    cur_req = "R1";
    idle(3);
    rst_n = 1;
    irq_en = 1;
    idle(2);

    // R2: hardware-corrected class 0 sets bit 33 and stays
    cur_req = "R2";
    send(0, 48'h0000_1000_0000, 9'h011, 4'h1, 0, 0);
    idle(3);
    // R4: repeat of a hardware-corrected class leaves bit 53 clear
    cur_req = "R4";
    send(0, 48'h0000_1000_0040, 9'h012, 4'h2, 0, 0);
    idle(1);

    // R7: uncorrectable overwrites, equal and lower ranks do not
    cur_req = "R7";
    send(1, 48'h0000_2000_0000, 9'h0A1, 4'h3, 0, 0);
    send(2, 48'h0000_3000_0000, 9'h0A2, 4'h4, 0, 0);
    send(3, 48'h0000_4000_0000, 9'h0A3, 4'h5, 0, 0);
    send(9, 48'h0000_5000_0000, 9'h0A4, 4'h6, 0, 0);
    idle(1);

    // R4: repeat of uncorrectable class 1 sets bit 53
    cur_req = "R4";
    send(1, 48'h0000_6000_0000, 9'h0B1, 4'h7, 0, 0);
    idle(1);

    // R3: zero writes and writes to read-only bits change nothing
    cur_req = "R3";
    wr(64'h0);
    wr(64'hFFC0_0001_FFFF_FFFF);
    wr(bitmask(2) | (64'd1 << 53));
    idle(1);

    // R8: clearing a non-held bit keeps the lock; clearing the held bit unlocks
    cur_req = "R8";
    wr(bitmask(3));
    send(5, 48'h0000_7000_0000, 9'h0C5, 4'h8, 0, 0);
    wr(bitmask(1));
    idle(2);
    send(0, 48'h0000_8000_0000, 9'h0C0, 4'h9, 0, 0);
    idle(1);

    // R9: tag classes capture only the tag syndrome
    cur_req = "R9";
    send(14, 48'h0000_9000_0000, 9'h1FF, 4'hA, 0, 0);
    send(12, 48'h0000_A000_0000, 9'h0D2, 4'hB, 0, 0);
    wr(bitmask(14));
    send(15, 48'h0000_B000_0000, 9'h0D3, 4'hC, 0, 0);
    idle(1);

    // R10: set and clear of the same bit in one cycle
    cur_req = "R10";
    wr(bitmask(0) | bitmask(5) | bitmask(9) | bitmask(12) | bitmask(15));
    send(1, 48'h0000_C000_0000, 9'h0E1, 4'hD, 0, 0);
    evt_valid = 1; evt_class = 5'd1; evt_addr = 48'h0000_D000_0000;
    evt_dsyn = 9'h0E2; evt_tsyn = 4'hE; wr_en = 1; wr_data = bitmask(1);
    step();
    idle_inputs();
    idle(1);

    // R5: events inside the same transfer are dropped
    cur_req = "R5";
    send(2, 48'h0000_E000_0000, 9'h0F2, 4'h1, 0, 0);
    send(9, 48'h0000_F000_0000, 9'h0F9, 4'h2, 1, 1);
    send(2, 48'h0001_0000_0000, 9'h0FA, 4'h3, 1, 0);
    idle(1);

    // R6: privilege captured on each event
    cur_req = "R6";
    send(6, 48'h0001_1000_0000, 9'h016, 4'h4, 0, 1);
    idle(1);
    send(7, 48'h0001_2000_0000, 9'h017, 4'h5, 0, 0);
    idle(1);

    // R12: out-of-range class ignored
    cur_req = "R12";
    send(19, 48'h0001_3000_0000, 9'h1AA, 4'hF, 0, 1);
    send(31, 48'h0001_4000_0000, 9'h1AB, 4'hF, 0, 1);
    idle(1);

    // R11: interrupt gating
    cur_req = "R11";
    irq_en = 0;
    idle(2);
    irq_en = 1;
    idle(1);
    wr(64'h003F_FFFE_0000_0000);
    idle(2);

    // Mixed random traffic against the model
    cur_req = "R2/R7";
    for (int n = 0; n < 3000; n++) begin
      evt_valid = ($urandom_range(0, 1) == 1);
      evt_class = 5'($urandom_range(0, 21));
      evt_same_txn = ($urandom_range(0, 9) == 0);
      evt_addr = ADDR_W'({$urandom(), $urandom()});
      evt_dsyn = 9'($urandom());
      evt_tsyn = 4'($urandom());
      priv_in = ($urandom_range(0, 1) == 1);
      wr_en = ($urandom_range(0, 4) == 0);
      wr_data = {$urandom(), $urandom()};
      irq_en = ($urandom_range(0, 3) != 0);
      step();
    end
    idle_inputs();
    idle(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule